// File: doc/BRIEF.md
# Programmable Clock-Output Divider Register

This block derives a slower output clock from the controller's oscillator clock, for use by an attached microcontroller. A single 8-bit configuration register sits at address 31 of a simple parallel register bus. Its low bits choose one of eight division ratios and can switch the output off. Its three top bits are mode flags that other logic picks up from dedicated output pins.

After a hardware reset the register takes one of two default values. The choice depends on which host bus style the host-mode input selects. Entering software reset mode has no effect on the register. Bit 4 is reserved: it cannot be written and always reads back as zero.

The divider gives a 50% duty cycle for every even ratio. A new ratio is applied only at an output edge, so no shortened pulse appears.

Top module: `clkout_ctrl`

## Requirements
- R1: While `rst` is high with `host_mode_sel` = 1, the register loads 8'h05. After reset it reads 8'h05 and `clkout` runs at the clock frequency divided by 12.
- R2: While `rst` is high with `host_mode_sel` = 0, the register loads 8'h00. After reset it reads 8'h00 and `clkout` runs at the clock frequency divided by 2.
- R3: A write with `bus_wr` = 1 and `bus_addr` = 31 stores bits 7, 6, 5, 3 and 2:0 of `bus_wdata`. Bit 4 cannot be written and always reads as 0. With `bus_rd` = 1 and `bus_addr` = 31, `bus_rdata` shows the register in the same cycle; at any other time it is 8'h00.
- R4: A write to any address other than 31 leaves the register unchanged.
- R5: `can_mode_o`, `cmp_bypass_o` and `rx_irq_route_o` follow register bits 7, 6 and 5.
- R6: Asserting `soft_reset` leaves the register contents and the output clock unchanged.
- R7: For divide code k in 0..6 (bits 2:0), `clkout` has period 2(k+1) clock cycles, with k+1 cycles high and k+1 cycles low.
- R8: Divide code 3'b111 passes the clock straight through to `clkout`: high in the high phase and low in the low phase of `clk`.
- R9: While the clock-off bit (bit 3) is 1, `clkout` stays low regardless of the divide code.
- R10: When clock-off is cleared by a write at clock edge E, `clkout` stays low for k+1 sampled cycles, starting at edge E, before its first rise.
- R11: A change of divide code takes effect at the next `clkout` transition. The phase in progress completes with the old length, and the next phase has the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| host_mode_sel | input | 1 | Host bus style; 1 selects the divide-by-12 default |
| soft_reset | input | 1 | Software reset mode indication; ignored by this register |
| bus_addr | input | 5 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero unless reading address 31 |
| clkout | output | 1 | Divided clock output |
| can_mode_o | output | 1 | Register bit 7 |
| cmp_bypass_o | output | 1 | Register bit 6 |
| rx_irq_route_o | output | 1 | Register bit 5 |

## Verification
A write lands at the clock edge where the strobe is sampled. Read data is combinational and is sampled 1 ns after the read strobe is applied, well before the next edge. The divider adds one more register stage: the new register value is first seen at the edge after the write, and the output only changes at its own transition edges.

For these reasons the bench samples `clkout` 1 ns after each rising edge and measures the lengths of high and low runs, rather than absolute phase. The only exception is the clock-off release and the code-change case. There the run is counted exactly from the write edge, so the expected lengths follow directly from that one-edge delay.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int CODE_W = 3;
    localparam int CNT_W  = CODE_W + 1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic  can_mode;
        logic  cmp_bypass;
        logic  rx_irq_route;
        logic  clk_off;
        code_t div_code;
    } cfg_t;

    localparam code_t CODE_PASS  = 3'b111;
    localparam code_t CODE_DIV12 = 3'b101;
    localparam code_t CODE_DIV2  = 3'b000;

    function automatic logic [7:0] cfg_to_byte(cfg_t c);
        return {c.can_mode, c.cmp_bypass, c.rx_irq_route, 1'b0, c.clk_off, c.div_code};
    endfunction

    function automatic cfg_t byte_to_cfg(logic [7:0] b);
        cfg_t c;
        c.can_mode     = b[7];
        c.cmp_bypass   = b[6];
        c.rx_irq_route = b[5];
        c.clk_off      = b[3];
        c.div_code     = b[2:0];
        return c;
    endfunction

    function automatic cfg_t hw_default(logic first_style);
        cfg_t c;
        c          = '0;
        c.div_code = first_style ? CODE_DIV12 : CODE_DIV2;
        return c;
    endfunction

    function automatic cnt_t half_period(code_t k);
        return {1'b0, k} + cnt_t'(1);
    endfunction

endpackage

// File: rtl/clkout_cfg_reg.sv
module clkout_cfg_reg
    import clkout_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode_sel,
    input  logic              soft_reset,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output cfg_t              cfg_o
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    cfg_t cfg_q;
    logic hit;
    logic wr_hit;

    assign hit    = (bus_addr == MY_ADDR);
    assign wr_hit = bus_wr && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= hw_default(host_mode_sel);
        end else if (wr_hit) begin
            cfg_q <= byte_to_cfg(bus_wdata);
        end
    end

    assign bus_rdata = (bus_rd && hit) ? cfg_to_byte(cfg_q) : 8'h00;
    assign cfg_o     = cfg_q;

    // R3: writable fields land one edge after the strobe
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (cfg_to_byte(cfg_q) == ($past(bus_wdata) & 8'hEF)));

    // R4: no change without an addressed write
    a_r4_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(cfg_q));

    // R6: software reset mode does not disturb the register
    a_r6_soft_keep: assert property (@(posedge clk) disable iff (rst)
        (soft_reset && !wr_hit) |=> $stable(cfg_q));

endmodule

// File: rtl/clkout_div.sv
module clkout_div
    import clkout_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t rst_code,
    input  cfg_t  cfg_i,
    output logic  clkout
);

    code_t act_q;
    cnt_t  cnt_q;
    logic  div_q;
    logic  at_edge;

    assign at_edge = (cnt_q == half_period(act_q) - cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= rst_code;
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (cfg_i.clk_off || act_q == CODE_PASS) begin
            act_q <= cfg_i.div_code;
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (at_edge) begin
            act_q <= cfg_i.div_code;
            cnt_q <= '0;
            div_q <= ~div_q;
        end else begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

    assign clkout = (act_q == CODE_PASS && !cfg_i.clk_off) ? clk : div_q;

    // R7: counter never passes the half period of the active ratio
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (act_q != CODE_PASS) |-> (cnt_q < half_period(act_q)));

    // R9: clock-off parks the divider low with the counter cleared
    a_r9_off_low: assert property (@(posedge clk) disable iff (rst)
        cfg_i.clk_off |=> (!div_q && cnt_q == '0));

    // R11: away from a transition the output and active ratio hold
    a_r11_hold_phase: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.clk_off && act_q != CODE_PASS && !at_edge) |=> ($stable(div_q) && $stable(act_q)));

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
    import clkout_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode_sel,
    input  logic              soft_reset,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              clkout,
    output logic              can_mode_o,
    output logic              cmp_bypass_o,
    output logic              rx_irq_route_o
);

    cfg_t  cfg;
    cfg_t  rst_cfg;

    assign rst_cfg = hw_default(host_mode_sel);

    clkout_cfg_reg #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_reg (
        .clk           (clk),
        .rst           (rst),
        .host_mode_sel (host_mode_sel),
        .soft_reset    (soft_reset),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .cfg_o         (cfg)
    );

    clkout_div u_div (
        .clk      (clk),
        .rst      (rst),
        .rst_code (rst_cfg.div_code),
        .cfg_i    (cfg),
        .clkout   (clkout)
    );

    assign can_mode_o     = cfg.can_mode;
    assign cmp_bypass_o   = cfg.cmp_bypass;
    assign rx_irq_route_o = cfg.rx_irq_route;

    // R5: flag outputs track a written byte one edge later
    a_r5_flags: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(REG_ADDR)) |=>
            ({can_mode_o, cmp_bypass_o, rx_irq_route_o} == $past(bus_wdata[7:5])));

endmodule

// File: tb/sim_clkout_ctrl.sv
module sim_clkout_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_mode_sel = 1'b1;
    logic       soft_reset = 1'b0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       clkout;
    logic       can_mode_o, cmp_bypass_o, rx_irq_route_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    clkout_ctrl u0 (
        .clk            (clk),
        .rst            (rst),
        .host_mode_sel  (host_mode_sel),
        .soft_reset     (soft_reset),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .clkout         (clkout),
        .can_mode_o     (can_mode_o),
        .cmp_bypass_o   (cmp_bypass_o),
        .rx_irq_route_o (rx_irq_route_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sample(output logic v);
        @(posedge clk);
        #1 v = clkout;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1; host_mode_sel = mode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // measure one high run and one low run of the sampled output
    task automatic check_ratio(input string req, input int half);
        logic prev, cur;
        int hi, lo;
        sample(prev);
        for (int i = 0; i < 100; i++) begin
            sample(cur);
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1; lo = 0;
        for (int i = 0; i < 40; i++) begin
            sample(cur);
            if (!cur) break;
            hi++;
        end
        lo = 1;
        for (int i = 0; i < 40; i++) begin
            sample(cur);
            if (cur) break;
            lo++;
        end
        chk({req, " high run"}, hi, half);
        chk({req, " low run"}, lo, half);
    endtask

    task automatic check_pass(input string req);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1 chk({req, " high phase"}, int'(clkout), 1);
            @(negedge clk); #1 chk({req, " low phase"}, int'(clkout), 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        logic v;
        int cnt;

        // R1: first bus style default
        do_reset(1'b1);
        rd_reg(5'd31, rd);
        chk("R1 default value", int'(rd), 8'h05);
        check_ratio("R1 divide by 12", 6);

        // R2: other bus style default
        do_reset(1'b0);
        rd_reg(5'd31, rd);
        chk("R2 default value", int'(rd), 8'h00);
        check_ratio("R2 divide by 2", 1);

        // R7 and R8: sweep all divide codes
        for (int k = 0; k < 8; k++) begin
            wr_reg(5'd31, 8'(k));
            repeat (40) @(posedge clk);
            if (k == 7) check_pass("R8 passthrough");
            else        check_ratio("R7 code sweep", k + 1);
        end

        // R3 and R5: write all ones, bit 4 reads zero, flags follow
        wr_reg(5'd31, 8'hFF);
        rd_reg(5'd31, rd);
        chk("R3 reserved bit reads zero", int'(rd), 8'hEF);
        chk("R5 flags all set", int'({can_mode_o, cmp_bypass_o, rx_irq_route_o}), 7);
        // R9: clock off holds output low
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            sample(v);
            if (v) cnt++;
        end
        chk("R9 off high samples", cnt, 0);
        @(negedge clk); #1 chk("R9 off in clock low phase", int'(clkout), 0);

        // R5: flag pattern 101
        wr_reg(5'd31, 8'hA3);
        chk("R5 flags 101", int'({can_mode_o, cmp_bypass_o, rx_irq_route_o}), 5);
        rd_reg(5'd31, rd);
        chk("R3 readback", int'(rd), 8'hA3);

        // R3: read strobe low or wrong address gives zero
        @(negedge clk); bus_addr = 5'd31; bus_rd = 1'b0;
        #1 chk("R3 no strobe reads zero", int'(bus_rdata), 0);
        rd_reg(5'd30, rd);
        chk("R3 other address reads zero", int'(rd), 0);

        // R4: write elsewhere has no effect
        wr_reg(5'd30, 8'h00);
        rd_reg(5'd31, rd);
        chk("R4 foreign write ignored", int'(rd), 8'hA3);

        // R6: software reset leaves register and clock alone
        @(negedge clk); soft_reset = 1'b1;
        repeat (6) @(negedge clk);
        rd_reg(5'd31, rd);
        soft_reset = 1'b0;
        chk("R6 register kept", int'(rd), 8'hA3);
        check_ratio("R6 ratio kept", 4);

        // R10: clear clock-off and count the first low phase (code 4, half 5)
        wr_reg(5'd31, 8'h0C);
        repeat (5) @(posedge clk);
        @(negedge clk);
        bus_addr = 5'd31; bus_wdata = 8'h04; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        v = clkout;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (v) break;
            cnt++;
            sample(v);
        end
        chk("R10 first low phase", cnt, 5);

        // R11: switch code 6 -> 0 in mid high phase
        wr_reg(5'd31, 8'h06);
        repeat (40) @(posedge clk);
        sample(v);
        for (int i = 0; i < 60; i++) begin
            logic c;
            sample(c);
            if (!v && c) break;
            v = c;
        end
        bus_addr = 5'd31; bus_wdata = 8'h00; bus_wr = 1'b1;
        cnt = 1;
        sample(v);
        bus_wr = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (!v) break;
            cnt++;
            sample(v);
        end
        chk("R11 current high phase kept", cnt, 7);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (v) break;
            cnt++;
            sample(v);
        end
        chk("R11 next phase uses new ratio", cnt, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule